// File: doc/BRIEF.md
# Frame Memory Write-Recovery and Retention Tester

This controller runs one of two self-contained checks on a 32-bit frame memory port and reports the first bad word. A pulse on `start` while idle launches the sub-test picked by `test_sel`. The write-recovery sub-test visits every address. At each address it writes a word and reads the same address back in the next cycle, then compares the result. It makes one ascending pass with all-zero data. A separate descending pass follows with all-one data.

The retention sub-test blanks the display through `video_off`. It fills the whole memory with zeros and waits a programmable hold time. Then it reads every word back and compares it. The same fill, wait and verify sequence is repeated with all-ones data. The display is released at the end. The hold time is held in a register in units of a slow tick, which comes from a clock divider. Its reset value is a parameter: with the defaults (50 000-cycle tick at 50 MHz, 5000 ticks) it stands for five seconds.

The first mismatch stops the run. It records the sub-test, the pass, the address, and the expected and observed words. It also raises `fail` together with `done` and frees the display.

Top module: `fbm_rtest_top`

## Requirements
- R1: After reset `busy`, `done`, `fail`, `video_off` and `mem_req` are 0 and every error-capture output is 0. `busy` is 1 while a sub-test runs.
- R2: Write-recovery pass 0 (test_sel=0) writes 0x00000000 to addresses 0 up to the last address in ascending order. Every write is followed in the very next cycle by a read of the same address, and the read data is compared one cycle after the read.
- R3: Write-recovery pass 1 starts after pass 0 succeeds. It writes 0xFFFFFFFF with the same write-then-read step, going from the last address down to 0.
- R4: Retention (test_sel=1) holds `video_off` at 1 for the whole run. It fills addresses 0..last with zeros, waits, then reads and compares 0..last, and repeats this with 0xFFFFFFFF. Write recovery never raises `video_off`.
- R5: The hold register resets to HOLD_RESET and is loaded from `hold_value` when `hold_load` is 1. In retention the first verify read comes exactly HOLD*TICK_DIV+3 cycles after the last fill write of that pass.
- R6: On the first mismatch the block sets `fail`=1 and `done`=1, issues no further memory access and captures the fields. These are `err_test` (0 write recovery, 1 retention), `err_pass` (0 zeros, 1 ones), `err_addr`, `err_exp` and `err_obs`. The captured values hold until the next start.
- R7: `video_off` is 0 whenever `done` is 1, both after an abort and after a normal finish.
- R8: A `start` pulse while `busy` is ignored. A `start` accepted when idle clears `done`, `fail` and all capture fields.
- R9: A run with no mismatch ends with `done`=1, `fail`=0 and capture fields 0. A passing write-recovery or retention run issues exactly 2*DEPTH writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, accepted when idle |
| test_sel | input | 1 | 0 write recovery, 1 retention |
| hold_load | input | 1 | Load strobe for the hold register |
| hold_value | input | HOLD_W | Hold time in ticks |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read |
| video_off | output | 1 | Display blanked during retention |
| busy | output | 1 | Sub-test running |
| done | output | 1 | Run finished (level, cleared on start) |
| fail | output | 1 | Run aborted on mismatch |
| err_test | output | 1 | Sub-test of the captured mismatch |
| err_pass | output | 1 | Pass of the captured mismatch |
| err_addr | output | ADDR_W | Address of the captured mismatch |
| err_exp | output | DATA_W | Expected word |
| err_obs | output | DATA_W | Observed word |

## Verification
Write recovery spends three cycles per address: write, read, compare. `done`, `fail` and the capture fields change at the clock edge that closes the compare cycle. The bench therefore polls them on falling edges and samples only after `done` has risen. A posedge monitor records the memory port every cycle. It checks that each recovery write is followed directly by a read of the same address. It also checks the order and data of every write. It measures the gap from the last fill write to the first verify read and compares it with HOLD*TICK_DIV+3, for several hold values as well as the reset value.

// File: rtl/fbm_rtest_pkg.sv
package fbm_rtest_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_WR_WRITE = 4'd1,
        ST_WR_READ  = 4'd2,
        ST_WR_CHECK = 4'd3,
        ST_RT_FILL  = 4'd4,
        ST_RT_HLOAD = 4'd5,
        ST_RT_HWAIT = 4'd6,
        ST_RT_READ  = 4'd7,
        ST_RT_CHECK = 4'd8
    } rtest_state_e;

    localparam logic SUB_WREC = 1'b0;
    localparam logic SUB_RET  = 1'b1;

endpackage

// File: rtl/fbm_rtest_tick_div.sv
module fbm_rtest_tick_div #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);

    generate
        if (TICK_DIV <= 1) begin : g_direct
            assign tick = !clear;
        end else begin : g_count
            localparam int CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                if (clear || cnt_q == LAST) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = (cnt_q == LAST) && !clear;

            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R5
        end
    endgenerate

endmodule

// File: rtl/fbm_rtest_hold_timer.sv
module fbm_rtest_hold_timer #(
    parameter int HOLD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    input  logic              tick,
    output logic              expired
);

    logic [HOLD_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

    AST_TIMER_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/fbm_rtest_err_capture.sv
module fbm_rtest_err_capture #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              in_test,
    input  logic              in_pass,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_exp,
    input  logic [DATA_W-1:0] in_obs,
    output logic              err_test,
    output logic              err_pass,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_exp,
    output logic [DATA_W-1:0] err_obs
);

    typedef struct packed {
        logic              valid;
        logic              test;
        logic              pass;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] exp;
        logic [DATA_W-1:0] obs;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (clear) begin
            rec_d = '0;
        end else if (capture && !rec_q.valid) begin
            rec_d.valid = 1'b1;
            rec_d.test  = in_test;
            rec_d.pass  = in_pass;
            rec_d.addr  = in_addr;
            rec_d.exp   = in_exp;
            rec_d.obs   = in_obs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign err_test = rec_q.test;
    assign err_pass = rec_q.pass;
    assign err_addr = rec_q.addr;
    assign err_exp  = rec_q.exp;
    assign err_obs  = rec_q.obs;

    AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_q.valid && !clear) |=> $stable(rec_q)); // R6

    AST_CAPTURE_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_q.valid) |-> (rec_q.exp != rec_q.obs)); // R6

endmodule

// File: rtl/fbm_rtest_top.sv
module fbm_rtest_top
    import fbm_rtest_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 32,
    parameter int HOLD_W     = 24,
    parameter int TICK_DIV   = 50000,
    parameter int HOLD_RESET = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              test_sel,
    input  logic              hold_load,
    input  logic [HOLD_W-1:0] hold_value,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              video_off,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              err_test,
    output logic              err_pass,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_exp,
    output logic [DATA_W-1:0] err_obs
);

    localparam logic [ADDR_W-1:0] ADDR_LAST  = '1;
    localparam logic [DATA_W-1:0] WORD_ZERO  = '0;
    localparam logic [DATA_W-1:0] WORD_ONES  = '1;
    localparam logic [HOLD_W-1:0] HOLD_INIT  = HOLD_W'(HOLD_RESET);

    typedef struct packed {
        rtest_state_e      st;
        logic [ADDR_W-1:0] addr;
        logic              pass;
        logic              sub;
        logic              done;
        logic              fail;
        logic              vid;
        logic [HOLD_W-1:0] hold;
    } ctrl_t;

    ctrl_t q, d;

    logic              tick;
    logic              expired;
    logic              tmr_load;
    logic              cap;
    logic              cap_clr;
    logic [DATA_W-1:0] exp_word;
    logic              mismatch;

    assign exp_word = q.pass ? WORD_ONES : WORD_ZERO;
    assign mismatch = (mem_rdata != exp_word);

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        cap      = 1'b0;
        cap_clr  = 1'b0;

        if (hold_load) begin
            d.hold = hold_value;
        end

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st    = test_sel ? ST_RT_FILL : ST_WR_WRITE;
                    d.addr  = '0;
                    d.pass  = 1'b0;
                    d.sub   = test_sel;
                    d.done  = 1'b0;
                    d.fail  = 1'b0;
                    d.vid   = test_sel;
                    cap_clr = 1'b1;
                end
            end
            ST_WR_WRITE: d.st = ST_WR_READ;
            ST_WR_READ:  d.st = ST_WR_CHECK;
            ST_WR_CHECK: begin
                if (mismatch) begin
                    cap    = 1'b1;
                    d.fail = 1'b1;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else if (!q.pass) begin
                    d.st = ST_WR_WRITE;
                    if (q.addr == ADDR_LAST) begin
                        d.pass = 1'b1;
                    end else begin
                        d.addr = q.addr + 1'b1;
                    end
                end else begin
                    if (q.addr == '0) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.addr = q.addr - 1'b1;
                        d.st   = ST_WR_WRITE;
                    end
                end
            end
            ST_RT_FILL: begin
                if (q.addr == ADDR_LAST) begin
                    d.addr = '0;
                    d.st   = ST_RT_HLOAD;
                end else begin
                    d.addr = q.addr + 1'b1;
                end
            end
            ST_RT_HLOAD: begin
                tmr_load = 1'b1;
                d.st     = ST_RT_HWAIT;
            end
            ST_RT_HWAIT: begin
                if (expired) begin
                    d.st = ST_RT_READ;
                end
            end
            ST_RT_READ: d.st = ST_RT_CHECK;
            ST_RT_CHECK: begin
                if (mismatch) begin
                    cap    = 1'b1;
                    d.fail = 1'b1;
                    d.done = 1'b1;
                    d.vid  = 1'b0;
                    d.st   = ST_IDLE;
                end else if (q.addr == ADDR_LAST) begin
                    d.addr = '0;
                    if (!q.pass) begin
                        d.pass = 1'b1;
                        d.st   = ST_RT_FILL;
                    end else begin
                        d.done = 1'b1;
                        d.vid  = 1'b0;
                        d.st   = ST_IDLE;
                    end
                end else begin
                    d.addr = q.addr + 1'b1;
                    d.st   = ST_RT_READ;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.hold <= HOLD_INIT;
        end else begin
            q <= d;
        end
    end

    fbm_rtest_tick_div #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_load),
        .tick  (tick)
    );

    fbm_rtest_hold_timer #(
        .HOLD_W (HOLD_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (q.hold),
        .tick     (tick),
        .expired  (expired)
    );

    fbm_rtest_err_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cap_clr),
        .capture  (cap),
        .in_test  (q.sub),
        .in_pass  (q.pass),
        .in_addr  (q.addr),
        .in_exp   (exp_word),
        .in_obs   (mem_rdata),
        .err_test (err_test),
        .err_pass (err_pass),
        .err_addr (err_addr),
        .err_exp  (err_exp),
        .err_obs  (err_obs)
    );

    assign mem_req   = (q.st == ST_WR_WRITE) || (q.st == ST_WR_READ) ||
                       (q.st == ST_RT_FILL)  || (q.st == ST_RT_READ);
    assign mem_we    = (q.st == ST_WR_WRITE) || (q.st == ST_RT_FILL);
    assign mem_addr  = q.addr;
    assign mem_wdata = q.pass ? WORD_ONES : WORD_ZERO;
    assign video_off = q.vid;
    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign fail      = q.fail;

    AST_RECOVERY_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !video_off) |=>
        (mem_req && !mem_we && mem_addr == $past(mem_addr))); // R2

    AST_WRITE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata == WORD_ZERO || mem_wdata == WORD_ONES)); // R3

    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RT_HWAIT) |-> (!mem_req && video_off)); // R4

    AST_VIDEO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !video_off); // R7

    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> !mem_req); // R6

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(q.sub)); // R8

endmodule

// File: tb/fbm_rtest_top_tb_top.sv
`timescale 1ns/1ps
module fbm_rtest_top_tb_top;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int HOLD_W = 8;
    localparam int TDIV   = 4;
    localparam int HRST   = 2;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              test_sel = 1'b0;
    logic              hold_load = 1'b0;
    logic [HOLD_W-1:0] hold_value = '0;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              video_off, busy, done, fail, err_test, err_pass;
    logic [ADDR_W-1:0] err_addr;
    logic [DATA_W-1:0] err_exp, err_obs;

    always #10 clk = ~clk;

    fbm_rtest_top #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .HOLD_W (HOLD_W),
        .TICK_DIV (TDIV), .HOLD_RESET (HRST)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .start (start), .test_sel (test_sel),
        .hold_load (hold_load), .hold_value (hold_value),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .video_off (video_off), .busy (busy), .done (done), .fail (fail),
        .err_test (err_test), .err_pass (err_pass), .err_addr (err_addr),
        .err_exp (err_exp), .err_obs (err_obs)
    );

    // memory model with fault injection: kind 1 flips masked bits on read,
    // kind 2 forces masked bits to zero on read, both at one address
    logic [DATA_W-1:0] marr [DEPTH];
    logic [1:0]        f_kind = 2'd0;
    logic [ADDR_W-1:0] f_addr = '0;
    logic [DATA_W-1:0] f_mask = '0;

    function automatic logic [DATA_W-1:0] seen(logic [DATA_W-1:0] v, logic [ADDR_W-1:0] a);
        if (a == f_addr && f_kind == 2'd1) return v ^ f_mask;
        if (a == f_addr && f_kind == 2'd2) return v & ~f_mask;
        return v;
    endfunction

    always @(posedge clk) begin
        if (mem_req && mem_we)  marr[mem_addr] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= seen(marr[mem_addr], mem_addr);
    end

    // port monitor
    int  cyc = 0;
    bit  mon_clr = 1'b0;
    int  n_wr, n_wrec, n_rfill, n_rread, order_err, follow_err;
    int  last_fill_cyc, first_read_cyc;
    bit  first_read_seen, vid_seen, prev_wrec;
    logic [ADDR_W-1:0] prev_addr;

    always @(posedge clk) begin
        cyc++;
        if (mon_clr) begin
            n_wr = 0; n_wrec = 0; n_rfill = 0; n_rread = 0;
            order_err = 0; follow_err = 0;
            last_fill_cyc = 0; first_read_cyc = 0;
            first_read_seen = 1'b0; vid_seen = 1'b0; prev_wrec = 1'b0;
        end else begin
            if (prev_wrec && !(mem_req && !mem_we && mem_addr == prev_addr))
                follow_err++;
            prev_wrec = 1'b0;
            if (video_off) vid_seen = 1'b1;
            if (mem_req && mem_we) begin
                n_wr++;
                if (!video_off) begin
                    int p, idx, ea;
                    p   = n_wrec / DEPTH;
                    idx = n_wrec % DEPTH;
                    ea  = (p == 0) ? idx : DEPTH - 1 - idx;
                    if (int'(mem_addr) != ea || mem_wdata != (p != 0 ? '1 : '0))
                        order_err++;
                    n_wrec++;
                    prev_wrec = 1'b1;
                    prev_addr = mem_addr;
                end else begin
                    int p;
                    p = n_rfill / DEPTH;
                    if (int'(mem_addr) != n_rfill % DEPTH || mem_wdata != (p != 0 ? '1 : '0))
                        order_err++;
                    n_rfill++;
                    last_fill_cyc = first_read_seen ? last_fill_cyc : cyc;
                end
            end else if (mem_req && video_off) begin
                if (!first_read_seen) begin
                    first_read_seen = 1'b1;
                    first_read_cyc  = cyc;
                end
                if (int'(mem_addr) != n_rread % DEPTH) order_err++;
                n_rread++;
            end
        end
    end

    int checks = 0;
    int failures = 0;

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_hold(int h);
        @(negedge clk);
        hold_load  = 1'b1;
        hold_value = HOLD_W'(h);
        @(negedge clk);
        hold_load  = 1'b0;
    endtask

    task automatic launch(bit sel);
        @(negedge clk);
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr  = 1'b0;
        start    = 1'b1;
        test_sel = sel;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, "R9 watchdog: run did not finish", done, 1);
    endtask

    typedef struct packed {
        logic        sel;
        logic [7:0]  hold;
        logic [1:0]  kind;
        logic [3:0]  faddr;
        logic [31:0] fmask;
        logic        efail;
        logic        epass;
        logic [3:0]  eaddr;
        logic [31:0] eexp;
        logic [31:0] eobs;
        logic [7:0]  ewr;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd0, 2'd0, 4'd0,  32'h0,        1'b0, 1'b0, 4'd0,  32'h0,        32'h0,        8'd32},
        '{1'b0, 8'd0, 2'd1, 4'd5,  32'h00000100, 1'b1, 1'b0, 4'd5,  32'h0,        32'h00000100, 8'd6},
        '{1'b0, 8'd0, 2'd2, 4'd9,  32'h80000001, 1'b1, 1'b1, 4'd9,  32'hFFFFFFFF, 32'h7FFFFFFE, 8'd23},
        '{1'b0, 8'd0, 2'd1, 4'd15, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd15, 32'h0,        32'hFFFFFFFF, 8'd16},
        '{1'b0, 8'd0, 2'd2, 4'd0,  32'h00000001, 1'b1, 1'b1, 4'd0,  32'hFFFFFFFF, 32'hFFFFFFFE, 8'd32},
        '{1'b1, 8'd3, 2'd0, 4'd0,  32'h0,        1'b0, 1'b0, 4'd0,  32'h0,        32'h0,        8'd32},
        '{1'b1, 8'd0, 2'd0, 4'd0,  32'h0,        1'b0, 1'b0, 4'd0,  32'h0,        32'h0,        8'd32},
        '{1'b1, 8'd1, 2'd1, 4'd0,  32'h00000001, 1'b1, 1'b0, 4'd0,  32'h0,        32'h00000001, 8'd16},
        '{1'b1, 8'd5, 2'd2, 4'd15, 32'h000000F0, 1'b1, 1'b1, 4'd15, 32'hFFFFFFFF, 32'hFFFFFF0F, 8'd32}
    };

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !fail, "R1 status after reset", {busy, done, fail}, 0);
        check(!video_off && !mem_req, "R1 port idle after reset", {video_off, mem_req}, 0);
        check(err_addr == 0 && err_obs == 0 && err_exp == 0, "R1 capture after reset", err_obs, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 reset value of the hold register
        launch(1'b1);
        check(busy == 1'b1, "R1 busy while running", busy, 1);
        wait_done();
        check(!fail, "R9 default hold run passes", fail, 0);
        check(first_read_cyc - last_fill_cyc == HRST * TDIV + 3, "R5 hold gap at reset value",
              first_read_cyc - last_fill_cyc, HRST * TDIV + 3);

        // vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            f_kind = v.kind; f_addr = v.faddr; f_mask = v.fmask;
            if (v.sel) load_hold(int'(v.hold));
            launch(v.sel);
            wait_done();
            check(fail == v.efail, $sformatf("R6/R9 vec%0d fail flag", i), fail, v.efail);
            check(err_pass == v.epass && err_addr == v.eaddr, $sformatf("R6 vec%0d pass/addr", i),
                  {err_pass, err_addr}, {v.epass, v.eaddr});
            check(err_exp == v.eexp && err_obs == v.eobs, $sformatf("R6 vec%0d exp/obs", i),
                  {err_exp, err_obs}, {v.eexp, v.eobs});
            check(err_test == (v.efail & v.sel), $sformatf("R6 vec%0d sub-test id", i),
                  err_test, v.efail & v.sel);
            check(n_wr == int'(v.ewr), $sformatf("R6/R9 vec%0d write count", i), n_wr, v.ewr);
            check(order_err == 0, $sformatf("R2/R3/R4 vec%0d address and data order", i), order_err, 0);
            check(follow_err == 0, $sformatf("R2 vec%0d read right after write", i), follow_err, 0);
            check(vid_seen == v.sel, $sformatf("R4 vec%0d video blanking", i), vid_seen, v.sel);
            check(!video_off, $sformatf("R7 vec%0d video released", i), video_off, 0);
            if (v.sel)
                check(first_read_cyc - last_fill_cyc == int'(v.hold) * TDIV + 3,
                      $sformatf("R5 vec%0d hold gap", i),
                      first_read_cyc - last_fill_cyc, int'(v.hold) * TDIV + 3);
            repeat (2) @(negedge clk);
            check(!mem_req && n_wr == int'(v.ewr), $sformatf("R6 vec%0d quiet after done", i), n_wr, v.ewr);
        end

        // R8 start while busy is ignored
        f_kind = 2'd1; f_addr = 4'd5; f_mask = 32'h00000100;
        launch(1'b0);
        repeat (4) @(negedge clk);
        check(busy == 1'b1, "R8 busy before second start", busy, 1);
        start = 1'b1; test_sel = 1'b1;
        @(negedge clk);
        start = 1'b0; test_sel = 1'b0;
        wait_done();
        check(err_test == 1'b0 && err_addr == 4'd5, "R8 second start ignored", {err_test, err_addr}, 5);
        check(vid_seen == 1'b0, "R8 no video blanking from ignored start", vid_seen, 0);

        // R8 new start clears previous result
        f_kind = 2'd0;
        launch(1'b0);
        check(!done && !fail, "R8 done/fail cleared on start", {done, fail}, 0);
        check(err_addr == 0 && err_obs == 0 && err_exp == 0, "R8 capture cleared on start", err_obs, 0);
        wait_done();
        check(!fail && err_obs == 0, "R9 clean run after failure", {fail, err_obs}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule